// File: doc/BRIEF.md
# Operand Effective Address Unit

This unit resolves the operand of a load from an instruction's address field and a three-bit mode code. It can return the field itself as the value. It can also form an address from the field, the index register, the base register or the program counter, and then fetch the operand through a single memory read port. For the indirect forms it first fetches a pointer word. Two of the modes combine indexing with indirection. One adds the index before the pointer fetch, the other adds it to the fetched pointer, and the two give different operands.

A request is presented with a one-cycle `start` pulse while the unit is idle. The unit then drives zero, one or two reads, each a single-cycle request whose data comes back registered in the following cycle. It ends with a one-cycle `done` pulse, with the operand held on `operand`. All address arithmetic wraps modulo 2^AW. The register file write-back and the memory array sit outside the unit.

Top module: `opaddr_unit`

## Requirements
- R1: Mode 0 (immediate) makes no memory read. `done` rises one cycle after the accepted start, and `operand` equals the address field zero-extended to DW bits.
- R2: Mode 1 (direct) reads memory at the address field and returns that word.
- R3: Mode 2 (indirect) reads a pointer word at the address field, then returns the word at the pointer's low AW bits.
- R4: Mode 3 (indexed) returns the word at (address field + index register) mod 2^AW.
- R5: Mode 4 (based) returns the word at (address field + base register) mod 2^AW.
- R6: Mode 5 (relative) treats the address field as a signed two's-complement offset and returns the word at (PC + offset) mod 2^AW.
- R7: Mode 6 (index, then indirect) reads the pointer at (address field + index) mod 2^AW, then returns the word at that pointer.
- R8: Mode 7 (indirect, then index) reads the pointer at the address field, then returns the word at (pointer + index) mod 2^AW. The index used is the one captured at start.
- R9: `done` is a single-cycle pulse. Counted from the clock edge that accepts `start`, it arrives 1 cycle later for mode 0, 3 cycles later for modes 1, 3, 4 and 5, and 5 cycles later for modes 2, 6 and 7. `busy` is low whenever `done` is high.
- R10: A `start` pulse while `busy` is high is ignored. The operation in flight completes with its own result, and no extra read or `done` follows.
- R11: While `rst_n` is low, `done`, `busy` and `mem_rd_en` are low, including when reset arrives in the middle of an operation.
- R12: Each read request lasts exactly one cycle and occurs only while `busy` is high. A mode issues exactly its number of reads (0, 1 or 2), and they go to the addresses named in R2 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted when idle |
| mode | input | 3 | Addressing mode code (R1 to R8) |
| addr_fld | input | AW | Instruction address field |
| idx_reg | input | AW | Index register value |
| base_reg | input | AW | Base register value |
| pc | input | AW | Program counter value |
| mem_rd_en | output | 1 | Memory read request, one cycle per read |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | DW | Registered read data, valid the cycle after the request |
| done | output | 1 | One-cycle pulse, operand valid |
| operand | output | DW | Resolved operand, held until the next result |
| busy | output | 1 | Operation in flight |

## Verification
The hardest case to reach is a second read whose address depends on data returned by the first. Two variants need it: the pointer fetch with the index already added, and the pointer plus an index captured several cycles earlier. The stimulus sweeps every address field through all eight modes. The bench memory returns a computed scramble of the address, so each pointer lands on an unrelated location, and index, base and PC values vary with the field so that sums wrap past the top of the address space. Separate sequences inject a `start` pulse and a reset into a two-read operation while it is still fetching.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

  typedef enum logic [2:0] {
    AM_IMM     = 3'd0,
    AM_DIR     = 3'd1,
    AM_IND     = 3'd2,
    AM_IDX     = 3'd3,
    AM_BASE    = 3'd4,
    AM_REL     = 3'd5,
    AM_IDX_IND = 3'd6,
    AM_IND_IDX = 3'd7
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PTR_REQ  = 3'd1,
    ST_PTR_WAIT = 3'd2,
    ST_OP_REQ   = 3'd3,
    ST_OP_WAIT  = 3'd4
  } ast_e;

  // modes whose first read fetches a pointer word
  function automatic logic f_needs_ptr(amode_e m);
    return (m == AM_IND) || (m == AM_IDX_IND) || (m == AM_IND_IDX);
  endfunction

endpackage

// File: rtl/opaddr_first.sv
// First-hop address: operand address for single-read modes,
// pointer address for the indirect modes.
module opaddr_first
  import opaddr_pkg::*;
#(
  parameter int AW = 8
) (
  input  amode_e          mode,
  input  logic [AW-1:0]   fld,
  input  logic [AW-1:0]   idx,
  input  logic [AW-1:0]   base,
  input  logic [AW-1:0]   pc,
  output logic [AW-1:0]   first_addr
);

  function automatic logic [AW-1:0] f_first(amode_e m, logic [AW-1:0] f,
                                            logic [AW-1:0] x, logic [AW-1:0] b,
                                            logic [AW-1:0] p);
    logic signed [AW-1:0] offs;
    offs = $signed(f);
    case (m)
      AM_IDX, AM_IDX_IND: return f + x;
      AM_BASE:            return f + b;
      AM_REL:             return p + $unsigned(offs);
      default:            return f;
    endcase
  endfunction

  assign first_addr = f_first(mode, fld, idx, base, pc);

endmodule

// File: rtl/opaddr_second.sv
// Second-hop address: formed from a fetched pointer word.
module opaddr_second
  import opaddr_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  amode_e          mode,
  input  logic [DW-1:0]   ptr_word,
  input  logic [AW-1:0]   idx,
  output logic [AW-1:0]   second_addr
);

  function automatic logic [AW-1:0] f_second(amode_e m, logic [AW-1:0] p,
                                             logic [AW-1:0] x);
    return (m == AM_IND_IDX) ? p + x : p;
  endfunction

  assign second_addr = f_second(mode, ptr_word[AW-1:0], idx);

endmodule

// File: rtl/opaddr_seq.sv
// Sequencer: zero, one or two single-cycle reads per request.
module opaddr_seq
  import opaddr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  amode_e mode,
  output ast_e   state,
  output logic   evt_accept,
  output logic   evt_imm,
  output logic   evt_ptr_ready,
  output logic   evt_op_ready,
  output logic   rd_req
);

  ast_e state_q, state_d;

  assign evt_accept    = start && (state_q == ST_IDLE);
  assign evt_imm       = evt_accept && (mode == AM_IMM);
  assign evt_ptr_ready = (state_q == ST_PTR_WAIT);
  assign evt_op_ready  = (state_q == ST_OP_WAIT);
  assign rd_req        = (state_q == ST_PTR_REQ) || (state_q == ST_OP_REQ);
  assign state         = state_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (evt_accept && !evt_imm)
          state_d = f_needs_ptr(mode) ? ST_PTR_REQ : ST_OP_REQ;
      end
      ST_PTR_REQ:  state_d = ST_PTR_WAIT;
      ST_PTR_WAIT: state_d = ST_OP_REQ;
      ST_OP_REQ:   state_d = ST_OP_WAIT;
      ST_OP_WAIT:  state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/opaddr_unit.sv
module opaddr_unit
  import opaddr_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] addr_fld,
  input  logic [AW-1:0] idx_reg,
  input  logic [AW-1:0] base_reg,
  input  logic [AW-1:0] pc,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          done,
  output logic [DW-1:0] operand,
  output logic          busy
);

  amode_e        mode_in;
  amode_e        mode_q;
  logic [AW-1:0] idx_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] first_addr;
  logic [AW-1:0] second_addr;
  logic          done_q;
  logic [DW-1:0] operand_q;
  ast_e          state;

  // named events for the checker
  logic evt_accept, evt_imm, evt_ptr_ready, evt_op_ready, rd_req;

  assign mode_in = amode_e'(mode);

  opaddr_seq seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode_in),
    .state(state), .evt_accept(evt_accept), .evt_imm(evt_imm),
    .evt_ptr_ready(evt_ptr_ready), .evt_op_ready(evt_op_ready),
    .rd_req(rd_req)
  );

  opaddr_first #(.AW(AW)) first_i (
    .mode(mode_in), .fld(addr_fld), .idx(idx_reg), .base(base_reg),
    .pc(pc), .first_addr(first_addr)
  );

  opaddr_second #(.AW(AW), .DW(DW)) second_i (
    .mode(mode_q), .ptr_word(mem_rd_data), .idx(idx_q),
    .second_addr(second_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= AM_IMM;
      idx_q  <= '0;
      addr_q <= '0;
    end else if (evt_accept) begin
      mode_q <= mode_in;
      idx_q  <= idx_reg;
      addr_q <= first_addr;
    end else if (evt_ptr_ready) begin
      addr_q <= second_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      operand_q <= '0;
    end else begin
      done_q <= evt_imm || evt_op_ready;
      if (evt_imm)           operand_q <= DW'(addr_fld);
      else if (evt_op_ready) operand_q <= mem_rd_data;
    end
  end

  assign mem_rd_en   = rd_req;
  assign mem_rd_addr = addr_q;
  assign done        = done_q;
  assign operand     = operand_q;
  assign busy        = (state != ST_IDLE);

endmodule

// File: rtl/opaddr_chk.sv
module opaddr_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode,
  input logic [AW-1:0] addr_fld,
  input logic [AW-1:0] idx_reg,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_rd_addr,
  input logic [DW-1:0] mem_rd_data,
  input logic          done,
  input logic          busy,
  input logic          evt_accept,
  input logic          evt_ptr_ready,
  input logic [2:0]    mode_q,
  input logic [AW-1:0] idx_q
);

  logic [AW-1:0] pre_sum;
  logic [AW-1:0] post_sum;
  assign pre_sum  = addr_fld + idx_reg;
  assign post_sum = mem_rd_data[AW-1:0] + idx_q;

  a_r12_rd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  a_r12_rd_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r1_imm_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && mode == 3'd0) |=> (done && !mem_rd_en && !busy));

  a_r2_direct_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && mode == 3'd1) |=> (mem_rd_en && mem_rd_addr == $past(addr_fld)));

  a_r7_pre_index: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && mode == 3'd6) |=> (mem_rd_en && mem_rd_addr == $past(pre_sum)));

  a_r8_post_index: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ptr_ready && mode_q == 3'd7) |=> (mem_rd_en && mem_rd_addr == $past(post_sum)));

  a_r10_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !evt_accept);

endmodule

bind opaddr_unit opaddr_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .addr_fld(addr_fld),
  .idx_reg(idx_reg), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
  .mem_rd_data(mem_rd_data), .done(done), .busy(busy),
  .evt_accept(evt_accept), .evt_ptr_ready(evt_ptr_ready),
  .mode_q(mode_q), .idx_q(idx_q)
);

// File: tb/opaddr_unit_tb_top.sv
`timescale 1ns/1ps
module opaddr_unit_tb_top;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    mode = '0;
  logic [AW-1:0] addr_fld = '0, idx_reg = '0, base_reg = '0, pc = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data = '0;
  logic          done;
  logic [DW-1:0] operand;
  logic          busy;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  opaddr_unit #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .addr_fld(addr_fld), .idx_reg(idx_reg), .base_reg(base_reg), .pc(pc),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .done(done), .operand(operand), .busy(busy)
  );

  // memory contents: computed scramble of the address
  function automatic int memw(int a);
    return ((a % 256) * 37 + 11) % 256;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= DW'(memw(int'(mem_rd_addr)));

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // results of the last operation
  int lat, nrd, ra0, ra1, res;

  task automatic issue(int m, int f, int x, int b, int p, bit poke);
    @(negedge clk);
    mode = 3'(m); addr_fld = AW'(f); idx_reg = AW'(x); base_reg = AW'(b); pc = AW'(p);
    start = 1'b1;
    lat = 0; nrd = 0; ra0 = -1; ra1 = -1; res = -1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= 8; c++) begin
      if (poke && c == 2) begin
        start = 1'b1; mode = 3'd0; addr_fld = AW'(f ^ 8'hFF);
      end else begin
        start = 1'b0;
      end
      if (mem_rd_en) begin
        if (nrd == 0) ra0 = int'(mem_rd_addr);
        else if (nrd == 1) ra1 = int'(mem_rd_addr);
        nrd++;
      end
      if (done) begin
        lat = c; res = int'(operand);
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic run_and_check(int m, int f, int x, int b, int p, bit poke);
    int ea, ptr, exp_res, exp_lat, exp_rd, offs;
    string tag;
    ptr = -1;
    offs = (f >= 128) ? f - 256 : f;
    case (m)
      0: begin tag = "R1"; ea = -1; end
      1: begin tag = "R2"; ea = f; end
      2: begin tag = "R3"; ptr = f; ea = memw(ptr); end
      3: begin tag = "R4"; ea = (f + x) % 256; end
      4: begin tag = "R5"; ea = (f + b) % 256; end
      5: begin tag = "R6"; ea = (p + offs + 256) % 256; end
      6: begin tag = "R7"; ptr = (f + x) % 256; ea = memw(ptr); end
      default: begin tag = "R8"; ptr = f; ea = (memw(ptr) + x) % 256; end
    endcase
    exp_res = (m == 0) ? f : memw(ea);
    exp_rd  = (m == 0) ? 0 : (ptr >= 0 ? 2 : 1);
    exp_lat = 1 + 2 * exp_rd;
    issue(m, f, x, b, p, poke);
    chk(res == exp_res, tag, res, exp_res);
    chk(lat == exp_lat, "R9 latency", lat, exp_lat);
    chk(nrd == exp_rd, "R12 read count", nrd, exp_rd);
    if (exp_rd == 2) begin
      chk(ra0 == ptr, "R12 pointer addr", ra0, ptr);
      chk(ra1 == ea, "R12 operand addr", ra1, ea);
    end else if (exp_rd == 1) begin
      chk(ra0 == ea, "R12 operand addr", ra0, ea);
    end
  endtask

  initial begin : watchdog
    #(5.0 * 200000);
    errors++;
    $display("FAIL R9 watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(done == 1'b0, "R11 done in reset", int'(done), 0);
    chk(busy == 1'b0, "R11 busy in reset", int'(busy), 0);
    chk(mem_rd_en == 1'b0, "R11 read in reset", int'(mem_rd_en), 0);
    rst_n = 1'b1;

    // sweep every address field through every mode
    for (int m = 0; m < 8; m++) begin
      for (int f = 0; f < 256; f++) begin
        run_and_check(m, f, (f * 3 + 1) % 256, f ^ 8'h5A, (255 - f * 7 + 2048) % 256, 1'b0);
      end
    end

    // R10: start pulse during a two-read operation is ignored
    run_and_check(7, 200, 100, 0, 0, 1'b1);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(done == 1'b0, "R10 no extra done", int'(done), 0);
      chk(mem_rd_en == 1'b0, "R10 no extra read", int'(mem_rd_en), 0);
    end
    run_and_check(6, 250, 9, 0, 0, 1'b1);

    // R11: reset in the middle of an operation
    @(negedge clk);
    mode = 3'd2; addr_fld = 8'd17; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    chk(busy == 1'b0, "R11 busy after mid reset", int'(busy), 0);
    chk(mem_rd_en == 1'b0, "R11 read after mid reset", int'(mem_rd_en), 0);
    chk(done == 1'b0, "R11 done after mid reset", int'(done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_and_check(1, 0, 0, 0, 0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule